// File: doc/BRIEF.md
# Spare Stream Status Unpacker and Error Counter

This unit sits on the read path behind a page error-correction engine. The engine returns the spare area of a page as a byte stream. After each chunk's spare bytes it inserts a four-byte status field. The unpacker removes every status field, so the spare bytes leave as one contiguous stream. From each status field it keeps the leading byte and classifies it. Across the page it tallies the total number of corrected bits, the largest per-step bitflip count, and the number of steps that could not be corrected.

Both streams are byte-wide valid/ready channels. Data bytes pass through combinationally, so a stalled consumer holds the producer back. Status bytes are taken whenever they are offered, because they never reach the output. Two static inputs configure the block: the number of spare bytes per step and the number of steps per page. At the end of each page a one-cycle result pulse marks the moment when the page summary on the result outputs becomes valid.

Top module: `spare_status_unpacker`

## Requirements
- R1: For each step, the first `cfg_step_bytes` accepted input bytes appear on the output unchanged and in order. The 4 bytes that follow are status bytes and are not forwarded. The output stream is therefore the concatenation of every step's spare bytes.
- R2: While a status byte is offered, `in_ready` is high whatever `out_ready` is, and `out_valid` is low.
- R3: While a spare byte is offered and `out_ready` is low, `in_ready` is low. No byte is lost or duplicated under any backpressure pattern.
- R4: A leading status byte of 0x00 changes none of the page counts.
- R5: A leading status byte of 0xFF marks an erased step and changes none of the page counts.
- R6: A leading status byte of 0xFE, or any value above 0x28, makes the step uncorrectable. It increments `res_fail_steps` and sets `res_failed`. `res_failed` equals (`res_fail_steps` != 0).
- R7: A leading status byte from 0x01 to 0x28 is added to `res_corrected`. It replaces `res_max_flips` if it is larger.
- R8: The second, third and fourth status bytes of each step have no effect on any result.
- R9: `res_valid` is high for exactly one cycle, in the cycle after the fourth status byte of the final step is accepted. The result outputs then hold until the first byte of the next page is accepted.
- R10: All page counts clear when the first spare byte of a page is accepted, so each page's result covers only that page.
- R11: After reset, `res_valid`, `out_valid`, and all result outputs are zero.
- R12: Any step size from 1 to 255 bytes and any step count from 1 to 16 is handled, including 255-byte steps and 16-step pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_step_bytes | input | 8 | Spare bytes per step (1 to 255) |
| cfg_steps | input | 5 | Steps per page (1 to 16) |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Output spare byte offered |
| out_data | output | 8 | Output spare byte |
| out_ready | input | 1 | Consumer accepts output byte |
| res_valid | output | 1 | One-cycle page-result pulse |
| res_failed | output | 1 | At least one step uncorrectable |
| res_max_flips | output | 8 | Largest corrected count of any step |
| res_corrected | output | 10 | Sum of corrected bits over the page |
| res_fail_steps | output | 5 | Number of uncorrectable steps |

## Verification
Spare bytes are due on the output in the same cycle they are offered, because the data path has no register. The monitor compares each byte it samples late in a cycle where `out_valid` and `out_ready` are both high against the head of the expected queue. The page result passes through one register, so it is due in the cycle right after the handshake on the final status byte. The monitor pops the expected record only when it sees `res_valid`, and it flags a pulse that lasts two sampled cycles. A few idle cycles after each page, the bench reads the held result again. It also checks that no pulse is missing by comparing the number of pulses with the number of pages sent.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int STAT_LEN = 4;
  localparam logic [7:0] CODE_CLEAN  = 8'h00;
  localparam logic [7:0] CODE_ERASED = 8'hFF;
  localparam logic [7:0] CODE_BAD    = 8'hFE;
  localparam logic [7:0] FIX_LIMIT   = 8'd40;

  typedef enum logic [1:0] {
    KIND_CLEAN  = 2'd0,
    KIND_ERASED = 2'd1,
    KIND_FIXED  = 2'd2,
    KIND_BAD    = 2'd3
  } stat_kind_e;
endpackage

// File: rtl/sst_framer.sv
module sst_framer
  import sst_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [STEP_W-1:0] cfg_steps,
  output logic              in_gap,
  output logic              page_first,
  output logic              gap_first,
  output logic              page_last
);
  localparam logic [LEN_W-1:0] GAP_LAST_IDX = LEN_W'(STAT_LEN - 1);

  logic              gap_q, gap_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              data_last, gap_last, step_last;

  always_comb begin
    data_last = !gap_q && (idx_q == LEN_W'(cfg_len - 1'b1));
    gap_last  = gap_q && (idx_q == GAP_LAST_IDX);
    step_last = (step_q == STEP_W'(cfg_steps - 1'b1));
    gap_d  = gap_q;
    idx_d  = idx_q;
    step_d = step_q;
    if (beat) begin
      if (data_last) begin
        gap_d = 1'b1;
        idx_d = '0;
      end else if (gap_last) begin
        gap_d  = 1'b0;
        idx_d  = '0;
        step_d = step_last ? '0 : step_q + 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 1'b0;
      idx_q  <= '0;
      step_q <= '0;
    end else if (beat) begin
      gap_q  <= gap_d;
      idx_q  <= idx_d;
      step_q <= step_d;
    end
  end

  assign in_gap     = gap_q;
  assign page_first = !gap_q && (idx_q == '0) && (step_q == '0);
  assign gap_first  = gap_q && (idx_q == '0);
  assign page_last  = gap_last && step_last;
endmodule

// File: rtl/sst_classify.sv
module sst_classify
  import sst_pkg::*;
(
  input  logic [7:0]  code,
  output stat_kind_e  kind,
  output logic [7:0]  flips
);
  always_comb begin
    flips = 8'd0;
    if (code == CODE_CLEAN) begin
      kind = KIND_CLEAN;
    end else if (code == CODE_ERASED) begin
      kind = KIND_ERASED;
    end else if (code == CODE_BAD || code > FIX_LIMIT) begin
      kind = KIND_BAD;
    end else begin
      kind  = KIND_FIXED;
      flips = code;
    end
  end
endmodule

// File: rtl/sst_tally.sv
module sst_tally
  import sst_pkg::*;
#(
  parameter int CORR_W  = 10,
  parameter int NFAIL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               take,
  input  stat_kind_e         kind,
  input  logic [7:0]         flips,
  input  logic               done,
  output logic               res_valid,
  output logic               res_failed,
  output logic [7:0]         res_max,
  output logic [CORR_W-1:0]  res_corr,
  output logic [NFAIL_W-1:0] res_nfail
);
  logic [7:0]         max_q, max_d;
  logic [CORR_W-1:0]  corr_q, corr_d;
  logic [NFAIL_W-1:0] nfail_q, nfail_d;
  logic               upd;
  logic               done_q;

  always_comb begin
    max_d   = max_q;
    corr_d  = corr_q;
    nfail_d = nfail_q;
    if (clr) begin
      max_d   = '0;
      corr_d  = '0;
      nfail_d = '0;
    end else if (take) begin
      if (kind == KIND_BAD) begin
        nfail_d = nfail_q + 1'b1;
      end else if (kind == KIND_FIXED) begin
        corr_d = corr_q + CORR_W'(flips);
        if (flips > max_q) max_d = flips;
      end
    end
  end

  assign upd = clr | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= '0;
      corr_q  <= '0;
      nfail_q <= '0;
    end else if (upd) begin
      max_q   <= max_d;
      corr_q  <= corr_d;
      nfail_q <= nfail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done;
  end

  assign res_valid  = done_q;
  assign res_failed = (nfail_q != '0);
  assign res_max    = max_q;
  assign res_corr   = corr_q;
  assign res_nfail  = nfail_q;
endmodule

// File: rtl/spare_status_unpacker.sv
module spare_status_unpacker
  import sst_pkg::*;
#(
  parameter int MAX_STEPS = 16,
  parameter int LEN_W     = 8,
  localparam int STEP_W   = $clog2(MAX_STEPS + 1),
  localparam int CORR_W   = $clog2(MAX_STEPS * 40 + 1),
  localparam int NFAIL_W  = $clog2(MAX_STEPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   cfg_step_bytes,
  input  logic [STEP_W-1:0]  cfg_steps,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  input  logic               out_ready,
  output logic               res_valid,
  output logic               res_failed,
  output logic [7:0]         res_max_flips,
  output logic [CORR_W-1:0]  res_corrected,
  output logic [NFAIL_W-1:0] res_fail_steps
);
  logic       in_gap, page_first, gap_first, page_last;
  logic       beat;
  stat_kind_e kind;
  logic [7:0] flips;

  assign in_ready  = in_gap | out_ready;
  assign out_valid = in_valid & ~in_gap;
  assign out_data  = in_data;
  assign beat      = in_valid & in_ready;

  sst_framer #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .cfg_len    (cfg_step_bytes),
    .cfg_steps  (cfg_steps),
    .in_gap     (in_gap),
    .page_first (page_first),
    .gap_first  (gap_first),
    .page_last  (page_last)
  );

  sst_classify u_class (
    .code  (in_data),
    .kind  (kind),
    .flips (flips)
  );

  sst_tally #(.CORR_W(CORR_W), .NFAIL_W(NFAIL_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (beat & page_first),
    .take       (beat & gap_first),
    .kind       (kind),
    .flips      (flips),
    .done       (beat & page_last),
    .res_valid  (res_valid),
    .res_failed (res_failed),
    .res_max    (res_max_flips),
    .res_corr   (res_corrected),
    .res_nfail  (res_fail_steps)
  );
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int CORR_W  = 10,
  parameter int NFAIL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               res_valid,
  input logic               res_failed,
  input logic [7:0]         res_max_flips,
  input logic [CORR_W-1:0]  res_corrected,
  input logic [NFAIL_W-1:0] res_fail_steps
);
  // R2
  status_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !out_ready) |-> !out_valid);

  // R3
  stall_holds_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  fail_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_failed == (res_fail_steps != '0)));

  // R7
  max_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_max_flips <= 8'd40));

  // R7
  max_within_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (CORR_W'(res_max_flips) <= res_corrected));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind spare_status_unpacker sst_checker #(.CORR_W(CORR_W), .NFAIL_W(NFAIL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .res_valid      (res_valid),
  .res_failed     (res_failed),
  .res_max_flips  (res_max_flips),
  .res_corrected  (res_corrected),
  .res_fail_steps (res_fail_steps)
);

// File: tb/spare_status_unpacker_test.sv
`timescale 1ns/1ps
module spare_status_unpacker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_step_bytes;
  logic [4:0] cfg_steps;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready;
  logic       res_valid;
  logic       res_failed;
  logic [7:0] res_max_flips;
  logic [9:0] res_corrected;
  logic [4:0] res_fail_steps;

  int n_checks = 0;
  int n_fail   = 0;
  int pages_sent = 0;
  int pulses_seen = 0;
  bit stall_on = 0;
  bit stall_bad = 0;
  bit prev_res = 0;
  logic [7:0] pat = 8'h11;

  logic [7:0] exp_q[$];
  int ex_failed[$];
  int ex_max[$];
  int ex_corr[$];
  int ex_nfail[$];
  int last_failed, last_max, last_corr, last_nfail;

  always #2 clk = ~clk;

  spare_status_unpacker uut (
    .clk(clk), .rst_n(rst_n), .cfg_step_bytes(cfg_step_bytes), .cfg_steps(cfg_steps),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .res_valid(res_valid), .res_failed(res_failed), .res_max_flips(res_max_flips),
    .res_corrected(res_corrected), .res_fail_steps(res_fail_steps)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always begin
    @(posedge clk);
    #1;
    out_ready = stall_on ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic put_byte(input logic [7:0] b);
    bit ok;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      #2;
      ok = in_ready;
      @(posedge clk);
      #1;
      if (ok) break;
    end
  endtask

  // Pushes expected bytes and the expected page record, then drives the page.
  task automatic send_page(input int len, input int steps, input logic [7:0] st[16]);
    int f = 0, mx = 0, co = 0, nf = 0;
    logic [7:0] data[$];
    cfg_step_bytes = 8'(len);
    cfg_steps      = 5'(steps);
    for (int s = 0; s < steps; s++) begin
      for (int i = 0; i < len; i++) begin
        data.push_back(pat);
        exp_q.push_back(pat);
        pat = pat * 8'd5 + 8'd3;
      end
      if (st[s] == 8'h00 || st[s] == 8'hFF) begin
      end else if (st[s] == 8'hFE || st[s] > 8'h28) begin
        nf++; f = 1;
      end else begin
        co += st[s];
        if (st[s] > mx) mx = st[s];
      end
    end
    ex_failed.push_back(f); ex_max.push_back(mx);
    ex_corr.push_back(co); ex_nfail.push_back(nf);
    last_failed = f; last_max = mx; last_corr = co; last_nfail = nf;
    pages_sent++;
    for (int s = 0; s < steps; s++) begin
      for (int i = 0; i < len; i++) put_byte(data.pop_front());
      // R8: trailing status bytes carry values that would count if used
      put_byte(st[s]);
      put_byte(8'hFE);
      put_byte(8'h27);
      put_byte(8'hFE);
    end
    in_valid = 1'b0;
  endtask

  // Monitor: sampled 1 ns before each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (rst_n) begin
        if (out_valid && !out_ready && in_ready) stall_bad = 1;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check("R1 unexpected byte", 1, 0);
          else check("R1 byte", out_data, exp_q.pop_front());
        end
        if (res_valid) begin
          pulses_seen++;
          if (prev_res) check("R9 pulse width", 2, 1);
          if (ex_failed.size() != 0) begin
            check("R6 res_failed", res_failed, ex_failed.pop_front());
            check("R7 res_max_flips", res_max_flips, ex_max.pop_front());
            check("R7 res_corrected", res_corrected, ex_corr.pop_front());
            check("R6 res_fail_steps", res_fail_steps, ex_nfail.pop_front());
          end
        end
        prev_res = res_valid;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    summary();
  end

  task automatic idle_hold_check();
    repeat (5) @(posedge clk);
    #3;
    // R9 result holds after the pulse
    check("R9 hold valid", res_valid, 0);
    check("R9 hold failed", res_failed, last_failed);
    check("R9 hold corrected", res_corrected, last_corr);
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] st[16];
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    cfg_step_bytes = 8'd3; cfg_steps = 5'd2;
    repeat (3) @(posedge clk);
    #3;
    // R11 reset state
    check("R11 res_valid", res_valid, 0);
    check("R11 out_valid", out_valid, 0);
    check("R11 res_corrected", res_corrected, 0);
    check("R11 res_fail_steps", res_fail_steps, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;

    // R4 and R7: clean plus corrected step
    foreach (st[i]) st[i] = 8'h00;
    st[1] = 8'h05;
    send_page(3, 2, st);
    idle_hold_check();

    // R5, R7 boundary 0x28, R3 under stalls
    stall_on = 1;
    st[0] = 8'hFF; st[1] = 8'h28; st[2] = 8'h01; st[3] = 8'h00;
    send_page(7, 4, st);
    idle_hold_check();

    // R6: 0xFE and 0x29 both fail, 0x10 still counted
    st[0] = 8'hFE; st[1] = 8'h29; st[2] = 8'h10;
    send_page(1, 3, st);
    idle_hold_check();

    // R10 and R12: fresh counts after a failed page, 16 steps
    foreach (st[i]) st[i] = 8'h03;
    send_page(2, 16, st);
    idle_hold_check();

    // R12: 255-byte single step
    stall_on = 0;
    st[0] = 8'h02;
    send_page(255, 1, st);
    idle_hold_check();

    repeat (4) @(posedge clk);
    check("R1 all bytes delivered", exp_q.size(), 0);
    check("R9 pulse count", pulses_seen, pages_sent);
    check("R3 input held during stall", stall_bad, 0);
    summary();
  end
endmodule